// File: doc/BRIEF.md
# Debug Trace Capture Buffer with Threshold Action

The block collects trace records from a capture source into a small first-in first-out store. Software drains it through a register port. Each record is wider than one register word, so it is read back as several word-wide slices. Reading the highest slice removes the record.

A control register holds two fields: a fill threshold and an action selector. When the occupancy climbs to the threshold, the selected action fires. The action either raises a debug interrupt or freezes capture. When the interrupt fires, a sticky cause bit is set and a fixed debug vector offset is presented to the exception logic. The request stays up until software writes 1 to the cause bit.

The capture side is a valid/ready stream. `trc_ready` is high when the store is neither full nor frozen, and a record moves on a cycle where `trc_valid` and `trc_ready` are both high. A producer that holds `trc_valid` while `trc_ready` is low is not stalled. That record is discarded and is never stored. When the discard is caused by a full store, an overflow cause bit is recorded.

Top module: `dbg_trace_fifo`

## Requirements
- R1: After reset the store is empty, `trc_ready` is 1, `irq_req` is 0, the control register reads 0 and the cause register reads 0.
- R2: A record is stored on a cycle with `trc_valid` and `trc_ready` both high. `trc_ready` is 0 whenever the store holds DEPTH records.
- R3: A record offered while the store is full is discarded and sets cause bit 1 (overflow). The occupancy never exceeds DEPTH.
- R4: The three port addresses 4, 5 and 6 return bits [31:0], [63:32] and [95:64] of the oldest record. Only a read of address 6 removes it; reads of addresses 4 and 5 leave it in place.
- R5: Any port read of an empty store returns 0 and does not move the read position.
- R6: The control register at address 0 holds the threshold in bits [7:0] and the action in bits [9:8]. Action 0 means none, 1 means interrupt, 2 means freeze capture, and 3 acts as none. A threshold of 0 disables the action.
- R7: With action 1, the cycle that raises the occupancy from below the threshold to the threshold sets cause bit 0 at that clock edge. From then on `irq_req` is 1, and `irq_vec` is 0x200 whenever `irq_req` is 1.
- R8: The cause register at address 1 is write-1-to-clear for bits 0 and 1. A threshold crossing in the same cycle as a clear leaves bit 0 set.
- R9: With action 2, the crossing drops `trc_ready` to 0. Records offered while frozen are discarded without setting the overflow bit. Any write to the control register releases the freeze.
- R10: A record stored and a record removed in the same cycle leave the occupancy unchanged, so that cycle does not count as a threshold crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trc_valid | input | 1 | Capture record offered |
| trc_ready | output | 1 | Store can accept a record |
| trc_data | input | 96 | Capture record |
| reg_sel | input | 1 | Register access this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq_req | output | 1 | Debug interrupt request, follows cause bit 0 |
| irq_vec | output | 12 | Vector offset, 0x200 while requesting |

## Verification
Two pairs of actions can meet in one cycle.

The first pair is a capture store and a slice-2 read. This pair is driven together while the occupancy sits one below the threshold. The record read back is compared against the scoreboard, and `irq_req` must stay low because the occupancy did not change.

The second pair is the store that reaches the threshold and a write-1-to-clear of cause bit 0. This pair is driven in a single step, and the request must still be high at the next falling edge.

// File: rtl/dtf_pkg.sv
package dtf_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_IRQ    = 2'd1,
    ACT_FREEZE = 2'd2,
    ACT_RSVD   = 2'd3
  } act_e;

  localparam int ADDR_W  = 3;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CAUSE = 3'd1;
  localparam logic [ADDR_W-1:0] A_PORT0 = 3'd4;

  localparam int TH_W    = 8;
  localparam int ACT_LSB = 8;

  localparam int CAUSE_IRQ = 0;
  localparam int CAUSE_OVF = 1;
endpackage

// File: rtl/dtf_store.sv
module dtf_store #(
  parameter int DEPTH = 8,
  parameter int W     = 96,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] occ,
  output logic             full,
  output logic             empty
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= adv(wr_ptr);
      if (pop)  rd_ptr <= adv(rd_ptr);
      case ({push, pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign full  = (occ == CNT_W'(DEPTH));
  assign empty = (occ == '0);
endmodule

// File: rtl/dtf_action.sv
module dtf_action import dtf_pkg::*; #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] occ,
  input  logic             push,
  input  logic             pop,
  input  logic [TH_W-1:0]  thresh,
  input  act_e             act,
  input  logic             cfg_wr,
  input  logic [1:0]       clr,
  input  logic             ovf,
  output logic [1:0]       cause,
  output logic             frozen
);
  int  cur_i, nxt_i, th_i;
  logic hit;

  always_comb begin
    cur_i = int'(occ);
    nxt_i = cur_i + int'(push) - int'(pop);
    th_i  = int'(thresh);
    hit   = (th_i != 0) && (cur_i < th_i) && (nxt_i >= th_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause  <= '0;
      frozen <= 1'b0;
    end else begin
      if (hit && act == ACT_IRQ)  cause[CAUSE_IRQ] <= 1'b1;
      else if (clr[CAUSE_IRQ])    cause[CAUSE_IRQ] <= 1'b0;
      if (ovf)                    cause[CAUSE_OVF] <= 1'b1;
      else if (clr[CAUSE_OVF])    cause[CAUSE_OVF] <= 1'b0;
      if (cfg_wr)                       frozen <= 1'b0;
      else if (hit && act == ACT_FREEZE) frozen <= 1'b1;
    end
  end
endmodule

// File: rtl/dtf_rdmux.sv
module dtf_rdmux import dtf_pkg::*; #(
  parameter int PORT_W    = 32,
  parameter int NUM_PORTS = 3
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic [PORT_W*NUM_PORTS-1:0] head,
  input  logic                        empty,
  input  logic [PORT_W-1:0]           ctrl_word,
  input  logic [PORT_W-1:0]           cause_word,
  output logic [PORT_W-1:0]           rdata
);
  logic [PORT_W-1:0] slice [NUM_PORTS];

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_slice
    assign slice[i] = empty ? '0 : head[i*PORT_W +: PORT_W];
  end

  always_comb begin
    rdata = '0;
    if (addr == A_CTRL)  rdata = ctrl_word;
    if (addr == A_CAUSE) rdata = cause_word;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (addr == A_PORT0 + ADDR_W'(i)) rdata = slice[i];
    end
  end
endmodule

// File: rtl/dbg_trace_fifo.sv
module dbg_trace_fifo import dtf_pkg::*; #(
  parameter int          DEPTH     = 8,
  parameter int          PORT_W    = 32,
  parameter int          NUM_PORTS = 3,
  parameter logic [11:0] VEC_OFS   = 12'h200
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        trc_valid,
  output logic                        trc_ready,
  input  logic [PORT_W*NUM_PORTS-1:0] trc_data,
  input  logic                        reg_sel,
  input  logic                        reg_wr,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [PORT_W-1:0]           reg_wdata,
  output logic [PORT_W-1:0]           reg_rdata,
  output logic                        irq_req,
  output logic [11:0]                 irq_vec
);
  localparam int REC_W = PORT_W * NUM_PORTS;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [ADDR_W-1:0] A_LAST = A_PORT0 + ADDR_W'(NUM_PORTS - 1);

  logic [TH_W-1:0]  thresh_q;
  act_e             act_q;
  logic [CNT_W-1:0] occ;
  logic [REC_W-1:0] head;
  logic             full, empty, frozen;
  logic [1:0]       cause, clr;
  logic             cfg_wr, cause_wr, push_acc, pop_acc, ovf;
  logic             unused_wdata;

  assign cfg_wr   = reg_sel && reg_wr && (reg_addr == A_CTRL);
  assign cause_wr = reg_sel && reg_wr && (reg_addr == A_CAUSE);
  assign clr      = cause_wr ? reg_wdata[1:0] : 2'b00;
  assign unused_wdata = ^reg_wdata[PORT_W-1:ACT_LSB+2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thresh_q <= '0;
      act_q    <= ACT_NONE;
    end else if (cfg_wr) begin
      thresh_q <= reg_wdata[TH_W-1:0];
      act_q    <= act_e'(reg_wdata[ACT_LSB+1:ACT_LSB]);
    end
  end

  assign trc_ready = !full && !frozen;
  assign push_acc  = trc_valid && trc_ready;
  assign ovf       = trc_valid && full && !frozen;
  assign pop_acc   = reg_sel && !reg_wr && (reg_addr == A_LAST) && !empty;

  dtf_store #(.DEPTH(DEPTH), .W(REC_W)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push_acc), .pop(pop_acc),
    .wdata(trc_data), .head(head), .occ(occ), .full(full), .empty(empty)
  );

  dtf_action #(.CNT_W(CNT_W)) u_action (
    .clk(clk), .rst_n(rst_n), .occ(occ), .push(push_acc), .pop(pop_acc),
    .thresh(thresh_q), .act(act_q), .cfg_wr(cfg_wr), .clr(clr), .ovf(ovf),
    .cause(cause), .frozen(frozen)
  );

  dtf_rdmux #(.PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS)) u_rdmux (
    .addr(reg_addr), .head(head), .empty(empty),
    .ctrl_word(PORT_W'({act_q, thresh_q})),
    .cause_word(PORT_W'(cause)),
    .rdata(reg_rdata)
  );

  assign irq_req = cause[CAUSE_IRQ];
  assign irq_vec = irq_req ? VEC_OFS : 12'h000;
endmodule

// File: rtl/dtf_chk.sv
module dtf_chk import dtf_pkg::*; #(
  parameter int          DEPTH   = 8,
  parameter int          CNT_W   = 4,
  parameter int          NUM_PORTS = 3,
  parameter logic [11:0] VEC_OFS = 12'h200
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trc_valid,
  input logic              trc_ready,
  input logic              reg_sel,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              clr0,
  input logic              irq_req,
  input logic [11:0]       irq_vec,
  input logic [CNT_W-1:0]  occ
);
  localparam logic [ADDR_W-1:0] A_LAST = A_PORT0 + ADDR_W'(NUM_PORTS - 1);
  logic stored, peek, clr_irq;
  assign stored  = trc_valid && trc_ready;
  assign peek    = reg_sel && !reg_wr && (reg_addr >= A_PORT0) && (reg_addr < A_LAST);
  assign clr_irq = reg_sel && reg_wr && (reg_addr == A_CAUSE) && clr0;

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CNT_W'(DEPTH)) |-> !trc_ready) else $error("full store accepts");  // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(occ) <= DEPTH)) else $error("occupancy past depth");  // R3
  AST_PEEK_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (peek && !stored) |=> $stable(occ)) else $error("low slice read popped");  // R4
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0 && !stored) |=> (occ == '0)) else $error("empty read moved");  // R5
  AST_VEC_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec == VEC_OFS)) else $error("wrong vector");  // R7
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !clr_irq) |=> irq_req) else $error("request dropped");  // R8
endmodule

bind dbg_trace_fifo dtf_chk #(
  .DEPTH(DEPTH), .CNT_W(CNT_W), .NUM_PORTS(NUM_PORTS), .VEC_OFS(VEC_OFS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .trc_valid(trc_valid), .trc_ready(trc_ready),
  .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr), .clr0(reg_wdata[0]),
  .irq_req(irq_req), .irq_vec(irq_vec), .occ(occ)
);

// File: tb/dbg_trace_fifo_tb_top.sv
module dbg_trace_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int PW    = 32;
  localparam int NP    = 3;
  localparam int RW    = PW * NP;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trc_valid = 1'b0;
  logic          trc_ready;
  logic [RW-1:0] trc_data = '0;
  logic          reg_sel = 1'b0;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [PW-1:0] reg_wdata = '0;
  logic [PW-1:0] reg_rdata;
  logic          irq_req;
  logic [11:0]   irq_vec;

  int n_vec = 0;
  int n_bad = 0;
  logic [RW-1:0] sb_q[$];

  dbg_trace_fifo #(.DEPTH(DEPTH), .PORT_W(PW), .NUM_PORTS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .trc_valid(trc_valid), .trc_ready(trc_ready),
    .trc_data(trc_data), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [RW-1:0] mk(input int k);
    return {32'hC000_0000 | 32'(k), 32'hB000_0000 | 32'(k), 32'hA000_0000 | 32'(k)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit pv, input int k, input bit rs, input bit rw,
                      input logic [2:0] ra, input logic [31:0] wd,
                      output logic [31:0] rd, output bit acc);
    trc_valid = pv; trc_data = mk(k);
    reg_sel = rs; reg_wr = rw; reg_addr = ra; reg_wdata = wd;
    #1;
    rd  = reg_rdata;
    acc = pv && trc_ready;
    if (acc) sb_q.push_back(mk(k));
    @(posedge clk);
    @(negedge clk);
    trc_valid = 1'b0; reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic push(input int k);
    logic [31:0] rd; bit acc;
    step(1'b1, k, 1'b0, 1'b0, 3'd0, 32'd0, rd, acc);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    logic [31:0] rd; bit acc;
    step(1'b0, 0, 1'b1, 1'b1, a, d, rd, acc);
  endtask

  task automatic rdreg(input logic [2:0] a, output logic [31:0] rd);
    bit acc;
    step(1'b0, 0, 1'b1, 1'b0, a, 32'd0, rd, acc);
  endtask

  // monitor: reads one entry slice by slice and compares with the scoreboard head
  task automatic drain_one(input string req);
    logic [31:0] rd;
    logic [RW-1:0] exp;
    exp = (sb_q.size() != 0) ? sb_q[0] : '0;
    for (int i = 0; i < NP; i++) begin
      rdreg(3'(4 + i), rd);
      chk(req, rd, exp[i*PW +: PW]);
    end
    if (sb_q.size() != 0) void'(sb_q.pop_front());
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    bit acc;
    logic [RW-1:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ready", 32'(trc_ready), 32'd1);
    chk("R1 irq", 32'(irq_req), 32'd0);
    rdreg(3'd1, rd); chk("R1 cause", rd, 32'd0);
    rdreg(3'd0, rd); chk("R1 ctrl", rd, 32'd0);
    rdreg(3'd6, rd); chk("R5 empty read", rd, 32'd0);

    // R4 slices and peeks
    push(1); push(2); push(3);
    rdreg(3'd4, rd); chk("R4 slice0", rd, 32'hA000_0001);
    rdreg(3'd5, rd); chk("R4 slice1", rd, 32'hB000_0001);
    rdreg(3'd4, rd); chk("R4 peek no pop", rd, 32'hA000_0001);
    drain_one("R4 entry"); drain_one("R4 entry"); drain_one("R4 entry");

    // R5 empty read leaves pointer
    drain_one("R5 empty zero");
    push(4);
    drain_one("R5 pointer held");

    // R2 / R3 full and overflow
    for (int k = 10; k < 10 + DEPTH; k++) push(k);
    chk("R2 ready low when full", 32'(trc_ready), 32'd0);
    push(99);
    rdreg(3'd1, rd); chk("R3 overflow bit", rd, 32'd2);
    for (int k = 0; k < DEPTH; k++) drain_one("R3 contents");
    drain_one("R3 dropped record absent");
    wr(3'd1, 32'd2);
    rdreg(3'd1, rd); chk("R8 overflow cleared", rd, 32'd0);

    // R7 interrupt at threshold 3
    wr(3'd0, 32'h103);
    rdreg(3'd0, rd); chk("R6 ctrl readback", rd, 32'h103);
    push(20); push(21);
    chk("R7 below threshold", 32'(irq_req), 32'd0);
    push(22);
    chk("R7 irq at threshold", 32'(irq_req), 32'd1);
    chk("R7 vector", 32'(irq_vec), 32'h200);
    rdreg(3'd1, rd); chk("R7 cause bit", rd, 32'd1);
    wr(3'd1, 32'd1);
    chk("R8 w1c clears irq", 32'(irq_req), 32'd0);
    drain_one("R7 entry");
    // R10 push and pop together at occupancy 2
    e = sb_q[0];
    step(1'b1, 24, 1'b1, 1'b0, 3'd6, 32'd0, rd, acc);
    chk("R10 popped slice2", rd, e[2*PW +: PW]);
    void'(sb_q.pop_front());
    chk("R10 no crossing", 32'(irq_req), 32'd0);
    // R8 crossing and clear in the same cycle
    step(1'b1, 25, 1'b1, 1'b1, 3'd1, 32'd1, rd, acc);
    chk("R8 set beats clear", 32'(irq_req), 32'd1);
    drain_one("R8 entry"); drain_one("R8 entry"); drain_one("R8 entry");
    chk("R8 sticky after drain", 32'(irq_req), 32'd1);
    wr(3'd1, 32'd1);

    // R6 threshold zero and action none
    wr(3'd0, 32'h100);
    push(30); push(31); push(32); push(33);
    chk("R6 threshold zero", 32'(irq_req), 32'd0);
    for (int k = 0; k < 4; k++) drain_one("R6 entry");
    wr(3'd0, 32'h003);
    push(34); push(35); push(36);
    chk("R6 action none", 32'(irq_req), 32'd0);
    for (int k = 0; k < 3; k++) drain_one("R6 entry");

    // R9 freeze
    wr(3'd0, 32'h202);
    push(40); push(41);
    chk("R9 frozen", 32'(trc_ready), 32'd0);
    push(42);
    rdreg(3'd1, rd); chk("R9 no overflow", rd, 32'd0);
    wr(3'd0, 32'h000);
    chk("R9 released", 32'(trc_ready), 32'd1);
    push(43);
    for (int k = 0; k < 3; k++) drain_one("R9 entry");
    drain_one("R9 empty");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule